// File: doc/BRIEF.md
# Transmitter Start Sequencing Controller

This block sits beside a serial audio transmitter and owns two of its registers: the global control word and the transmit status word. Software brings the transmitter up by setting one release bit per write, in a fixed order. The order is high-frequency divider, then bit-clock divider, then serializer, then state machine, then frame-sync generator. The block refuses any release whose predecessor has not yet confirmed. A release bit reads back as 1 one cycle after its unit has left reset, so software polls each bit before writing the next.

The state machine cannot be released while the buffer-empty status flag shows that the transmit buffer still waits for its first word. DMA requests for buffer refills are issued only after the frame-sync generator has confirmed. A DMA-disable bit also gates them, and that bit is set at reset. When the running state machine asks for a word and the buffer is empty, a sticky underrun flag is set. That flag drives the interrupt output when its enable bit is set. Writing zero to the control word drops every release at once.

Top module: `tx_start_seq`

## Requirements
- R1: After reset, all five release outputs are 0, `ctrl_rd_o` is 0, `stat_rd_o` is 0, `dma_req_o` is 0 and `irq_o` is 0.
- R2: Control register (`wr_addr_i`=0) bit positions: bit 9 high-frequency divider, bit 8 bit-clock divider, bit 10 serializer, bit 11 state machine, bit 12 frame sync. An accepted bit drives its release output from the clock edge that takes the write, and reads back as 1 in `ctrl_rd_o` one edge later.
- R3: A release bit is taken only if its predecessor in the order (high-frequency, bit-clock, serializer, state machine, frame sync) is set by the same write and already reads back as 1. Any other requested bit is stored as 0.
- R4: The state machine bit cannot be newly set while status bit 5 is 1. Status bit 5 is the buffer-empty input, registered one cycle.
- R5: A control write of zero clears all release outputs at the taking edge, and all readback bits one edge later.
- R6: Status bit 0 (underrun) is set one edge after a cycle in which `word_req_i` and `buf_empty_i` are both 1 and the state-machine readback is 1. It then stays set until cleared.
- R7: A status write (`wr_addr_i`=1) clears each sticky flag whose data bit is 1. A flag set in the same cycle stays set. Bits 5 and 8 are not affected by the write.
- R8: Status bit 8 is the OR of status bits 0, 1, 2 and 7.
- R9: `flag_set_i` bits 1, 2, 3, 4, 6 and 7 set the matching sticky status bits one edge later. `flag_set_i` bits 0, 5 and 8 are ignored.
- R10: `dma_req_o` is 1 exactly when `buf_empty_i` is 1, the frame-sync readback is 1, and the DMA-disable bit is 0. The DMA-disable bit is written at bit 0 of `wr_addr_i`=2 and reset to 1.
- R11: `irq_o` is 1 exactly when status bit 0 is 1 and the interrupt enable is 1. The interrupt enable is written at bit 0 of `wr_addr_i`=3 and reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 control, 1 status clear, 2 DMA control, 3 interrupt enable |
| wr_data_i | input | 16 | Write data |
| buf_empty_i | input | 1 | Transmit buffer needs data |
| word_req_i | input | 1 | Serializer wants the next word |
| flag_set_i | input | 9 | Set pulses for the other status flags |
| ctrl_rd_o | output | 16 | Control readback (confirmed releases) |
| stat_rd_o | output | 9 | Status word |
| hclk_rel_o | output | 1 | High-frequency divider release |
| bclk_rel_o | output | 1 | Bit-clock divider release |
| ser_rel_o | output | 1 | Serializer release |
| sm_rel_o | output | 1 | State machine release |
| fs_rel_o | output | 1 | Frame-sync generator release |
| dma_req_o | output | 1 | Buffer refill DMA request |
| irq_o | output | 1 | Underrun interrupt |

## Verification
Release outputs change at the edge that takes a control write, so the bench drives each write at a falling edge and checks the outputs at the next falling edge. It checks the readback one falling edge after that. Sticky flags and status bit 5 are registered once and are sampled one falling edge after their cause. `dma_req_o` and `irq_o` follow their register inputs with no delay and are checked in the same half-cycle. The 32 possible control masks are swept from a fully released state and compared against a prefix model of the release order. The flag-set inputs are also swept bit by bit.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  localparam int unsigned NUM_UNITS = 5;
  localparam int unsigned STAT_W    = 9;
  localparam int unsigned REG_W     = 16;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_DMA   = 2'd2,
    SEL_IRQEN = 2'd3
  } reg_sel_e;

  // index = release order
  localparam int unsigned U_HCLK = 0;
  localparam int unsigned U_BCLK = 1;
  localparam int unsigned U_SER  = 2;
  localparam int unsigned U_SM   = 3;
  localparam int unsigned U_FS   = 4;

  localparam int unsigned CB_BCLK = 8;
  localparam int unsigned CB_HCLK = 9;
  localparam int unsigned CB_SER  = 10;
  localparam int unsigned CB_SM   = 11;
  localparam int unsigned CB_FS   = 12;

  localparam int unsigned SB_URUN = 0;
  localparam int unsigned SB_DRDY = 5;
  localparam int unsigned SB_SUM  = 8;

  localparam logic [STAT_W-1:0] STICKY_MASK  = 9'h0DF;
  localparam logic [STAT_W-1:0] EXT_SET_MASK = 9'h0DE;
  localparam logic [STAT_W-1:0] SUM_MASK     = 9'h087;

  function automatic logic [NUM_UNITS-1:0] ctrl_to_order(input logic [REG_W-1:0] d);
    logic [NUM_UNITS-1:0] m;
    m[U_HCLK] = d[CB_HCLK];
    m[U_BCLK] = d[CB_BCLK];
    m[U_SER]  = d[CB_SER];
    m[U_SM]   = d[CB_SM];
    m[U_FS]   = d[CB_FS];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] order_to_ctrl(input logic [NUM_UNITS-1:0] m);
    logic [REG_W-1:0] d;
    d = '0;
    d[CB_HCLK] = m[U_HCLK];
    d[CB_BCLK] = m[U_BCLK];
    d[CB_SER]  = m[U_SER];
    d[CB_SM]   = m[U_SM];
    d[CB_FS]   = m[U_FS];
    return d;
  endfunction
endpackage

// File: rtl/tx_rel_chain.sv
module tx_rel_chain #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] hold_i,
  output logic [N-1:0] rel_o,
  output logic [N-1:0] ack_o
);
  logic [N-1:0] rel_q, ack_q, nxt;

  // bit k taken only behind a confirmed, retained predecessor
  always_comb begin
    logic run;
    run = 1'b1;
    nxt = '0;
    for (int k = 0; k < N; k++) begin
      nxt[k] = mask_i[k] & run & (~hold_i[k] | ack_q[k]);
      run    = nxt[k] & ack_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q <= '0;
      ack_q <= '0;
    end else begin
      if (wr_i) rel_q <= nxt;
      ack_q <= rel_q;
    end
  end

  assign rel_o = rel_q;
  assign ack_o = ack_q;
endmodule

// File: rtl/tx_stat_reg.sv
module tx_stat_reg
  import tx_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [STAT_W-1:0] clr_mask_i,
  input  logic              buf_empty_i,
  input  logic              urun_i,
  input  logic [STAT_W-1:0] flag_set_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] sticky_q, set_v, clr_v;
  logic              drdy_q;

  always_comb begin
    set_v          = flag_set_i & EXT_SET_MASK;
    set_v[SB_URUN] = urun_i;
    clr_v          = clr_i ? (clr_mask_i & STICKY_MASK) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_q <= '0;
      drdy_q   <= 1'b0;
    end else begin
      sticky_q <= ((sticky_q & ~clr_v) | set_v) & STICKY_MASK;
      drdy_q   <= buf_empty_i;
    end
  end

  always_comb begin
    stat_o          = sticky_q;
    stat_o[SB_DRDY] = drdy_q;
    stat_o[SB_SUM]  = |(sticky_q & SUM_MASK);
  end
endmodule

// File: rtl/tx_evt_ctl.sv
module tx_evt_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_dma_i,
  input  logic wr_ie_i,
  input  logic wr_bit_i,
  input  logic fs_ack_i,
  input  logic buf_empty_i,
  input  logic urun_i,
  output logic dma_req_o,
  output logic irq_o
);
  logic dma_dis_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_dis_q <= 1'b1;
      ie_q      <= 1'b0;
    end else begin
      if (wr_dma_i) dma_dis_q <= wr_bit_i;
      if (wr_ie_i)  ie_q      <= wr_bit_i;
    end
  end

  assign dma_req_o = buf_empty_i & fs_ack_i & ~dma_dis_q;
  assign irq_o     = urun_i & ie_q;
endmodule

// File: rtl/tx_start_seq.sv
module tx_start_seq
  import tx_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              buf_empty_i,
  input  logic              word_req_i,
  input  logic [STAT_W-1:0] flag_set_i,
  output logic [REG_W-1:0]  ctrl_rd_o,
  output logic [STAT_W-1:0] stat_rd_o,
  output logic              hclk_rel_o,
  output logic              bclk_rel_o,
  output logic              ser_rel_o,
  output logic              sm_rel_o,
  output logic              fs_rel_o,
  output logic              dma_req_o,
  output logic              irq_o
);
  reg_sel_e             sel;
  logic [NUM_UNITS-1:0] rel, ack, hold;
  logic [STAT_W-1:0]    stat;
  logic                 urun_ev;

  assign sel = reg_sel_e'(wr_addr_i);

  always_comb begin
    hold       = '0;
    hold[U_SM] = stat[SB_DRDY];
  end

  tx_rel_chain #(.N(NUM_UNITS)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i && sel == SEL_CTRL),
    .mask_i (ctrl_to_order(wr_data_i)),
    .hold_i (hold),
    .rel_o  (rel),
    .ack_o  (ack)
  );

  assign urun_ev = word_req_i & buf_empty_i & ack[U_SM];

  tx_stat_reg u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (wr_en_i && sel == SEL_STAT),
    .clr_mask_i  (wr_data_i[STAT_W-1:0]),
    .buf_empty_i (buf_empty_i),
    .urun_i      (urun_ev),
    .flag_set_i  (flag_set_i),
    .stat_o      (stat)
  );

  tx_evt_ctl u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_dma_i    (wr_en_i && sel == SEL_DMA),
    .wr_ie_i     (wr_en_i && sel == SEL_IRQEN),
    .wr_bit_i    (wr_data_i[0]),
    .fs_ack_i    (ack[U_FS]),
    .buf_empty_i (buf_empty_i),
    .urun_i      (stat[SB_URUN]),
    .dma_req_o   (dma_req_o),
    .irq_o       (irq_o)
  );

  assign ctrl_rd_o  = order_to_ctrl(ack);
  assign stat_rd_o  = stat;
  assign hclk_rel_o = rel[U_HCLK];
  assign bclk_rel_o = rel[U_BCLK];
  assign ser_rel_o  = rel[U_SER];
  assign sm_rel_o   = rel[U_SM];
  assign fs_rel_o   = rel[U_FS];
endmodule

// File: rtl/tx_start_seq_chk.sv
module tx_start_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_addr_i,
  input logic [15:0] wr_data_i,
  input logic        buf_empty_i,
  input logic        word_req_i,
  input logic [8:0]  flag_set_i,
  input logic [15:0] ctrl_rd_o,
  input logic [8:0]  stat_rd_o,
  input logic        hclk_rel_o,
  input logic        bclk_rel_o,
  input logic        ser_rel_o,
  input logic        sm_rel_o,
  input logic        fs_rel_o,
  input logic        dma_req_o,
  input logic        irq_o
);
  // R2
  hclk_confirm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hclk_rel_o) |=> ctrl_rd_o[9]);
  // R3
  bclk_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_rel_o) |-> ctrl_rd_o[9]);
  // R3
  fs_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fs_rel_o) |-> ctrl_rd_o[11]);
  // R4
  sm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sm_rel_o) |-> !$past(stat_rd_o[5]));
  // R5
  stop_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd0 && wr_data_i == 16'h0)
      |=> !(hclk_rel_o || bclk_rel_o || ser_rel_o || sm_rel_o || fs_rel_o));
  // R6
  underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_req_i && buf_empty_i && ctrl_rd_o[11]) |=> stat_rd_o[0]);
  // R10
  dma_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (buf_empty_i && ctrl_rd_o[12]));
  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_rd_o[0]);
endmodule

bind tx_start_seq tx_start_seq_chk u_chk (.*);

// File: tb/tb_tx_start_seq.sv
`timescale 1ns/1ps
module tb_tx_start_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        buf_empty_i = 1'b0;
  logic        word_req_i = 1'b0;
  logic [8:0]  flag_set_i = '0;
  logic [15:0] ctrl_rd_o;
  logic [8:0]  stat_rd_o;
  logic        hclk_rel_o, bclk_rel_o, ser_rel_o, sm_rel_o, fs_rel_o;
  logic        dma_req_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  tx_start_seq dut (.*);

  function automatic logic [15:0] cw(input logic [4:0] m);
    logic [15:0] d = '0;
    d[9] = m[0]; d[8] = m[1]; d[10] = m[2]; d[11] = m[3]; d[12] = m[4];
    return d;
  endfunction

  function automatic logic [4:0] prefix(input logic [4:0] m);
    logic [4:0] o = '0;
    logic run = 1'b1;
    for (int k = 0; k < 5; k++) begin
      run = run & m[k];
      o[k] = run;
    end
    return o;
  endfunction

  function automatic logic [4:0] rels();
    return {fs_rel_o, sm_rel_o, ser_rel_o, bclk_rel_o, hclk_rel_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic bring_up();
    wr(2'd0, 16'h0);
    tick();
    for (int k = 0; k < 5; k++) begin
      wr(2'd0, cw(5'((1 << (k + 1)) - 1)));
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1
    chk("R1 rel", rels(), 0);
    chk("R1 ctrl", ctrl_rd_o, 0);
    chk("R1 stat", stat_rd_o, 0);
    chk("R1 dma", dma_req_o, 0);
    chk("R1 irq", irq_o, 0);

    // R3: out of order
    wr(2'd0, cw(5'b00010));
    chk("R3 bclk alone", rels(), 0);
    wr(2'd0, cw(5'b11111));
    chk("R3 all at once", rels(), 5'b00001);
    chk("R2 readback lag", ctrl_rd_o, 0);
    tick();
    chk("R2 readback", ctrl_rd_o, cw(5'b00001));
    chk("R2 bit9", ctrl_rd_o[9], 1);

    // R2/R3 exhaustive from fully released state
    for (int m = 0; m < 32; m++) begin
      bring_up();
      chk("R2 up", rels(), 5'b11111);
      wr(2'd0, cw(5'(m)));
      chk("R3 sweep rel", rels(), prefix(5'(m)));
      tick();
      chk("R2 sweep ack", ctrl_rd_o, cw(prefix(5'(m))));
    end

    // R5
    bring_up();
    wr(2'd0, 16'h0);
    chk("R5 rel", rels(), 0);
    chk("R5 ack lag", ctrl_rd_o, cw(5'b11111));
    tick();
    chk("R5 ack", ctrl_rd_o, 0);

    // R4
    wr(2'd0, cw(5'b00001)); tick();
    wr(2'd0, cw(5'b00011)); tick();
    wr(2'd0, cw(5'b00111)); tick();
    buf_empty_i = 1'b1;
    tick();
    chk("R4 drdy", stat_rd_o[5], 1);
    wr(2'd0, cw(5'b01111));
    chk("R4 sm held", rels(), 5'b00111);
    wr(2'd1, 16'h1FF);
    chk("R7 drdy not cleared", stat_rd_o[5], 1);
    buf_empty_i = 1'b0;
    tick();
    chk("R4 drdy low", stat_rd_o[5], 0);
    wr(2'd0, cw(5'b01111));
    chk("R4 sm taken", rels(), 5'b01111);
    tick();

    // R6: sm running, no underrun yet
    word_req_i = 1'b1;
    tick();
    chk("R6 no underrun full buf", stat_rd_o[0], 0);
    buf_empty_i = 1'b1;
    tick();
    word_req_i = 1'b0;
    tick();
    chk("R6 underrun", stat_rd_o[0], 1);
    chk("R8 summary", stat_rd_o[8], 1);
    chk("R11 irq masked", irq_o, 0);
    wr(2'd3, 16'h1);
    chk("R11 irq", irq_o, 1);
    tick();
    chk("R6 sticky", stat_rd_o[0], 1);
    // R7 clear with set same cycle
    @(negedge clk_i);
    word_req_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd1; wr_data_i = 16'h1;
    @(negedge clk_i);
    word_req_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    chk("R7 set wins", stat_rd_o[0], 1);
    wr(2'd1, 16'h1);
    chk("R7 cleared", stat_rd_o[0], 0);
    chk("R11 irq off", irq_o, 0);
    chk("R8 summary off", stat_rd_o[8], 0);

    // R10
    buf_empty_i = 1'b0;
    tick();
    wr(2'd0, cw(5'b11111));
    tick();
    buf_empty_i = 1'b1;
    #1;
    chk("R10 disabled", dma_req_o, 0);
    wr(2'd2, 16'h0);
    chk("R10 req", dma_req_o, 1);
    buf_empty_i = 1'b0;
    #1;
    chk("R10 full", dma_req_o, 0);
    buf_empty_i = 1'b1;
    wr(2'd0, cw(5'b01111));
    chk("R10 fs ack lag", dma_req_o, 1);
    tick();
    chk("R10 fs off", dma_req_o, 0);

    // R6: no underrun without state machine
    wr(2'd0, 16'h0); tick();
    wr(2'd1, 16'h1FF);
    word_req_i = 1'b1;
    tick(); tick();
    word_req_i = 1'b0;
    chk("R6 idle no underrun", stat_rd_o[0], 0);
    buf_empty_i = 1'b0;
    tick();

    // R9/R8 flag sweep
    for (int b = 0; b < 9; b++) begin
      logic [8:0] e;
      e = 9'h0;
      if (b inside {1, 2, 3, 4, 6, 7}) e[b] = 1'b1;
      if (b inside {1, 2, 7}) e[8] = 1'b1;
      @(negedge clk_i);
      flag_set_i = 9'(1 << b);
      @(negedge clk_i);
      flag_set_i = '0;
      chk("R9 flag", stat_rd_o, e);
      wr(2'd1, 16'h1FF);
      chk("R7 clear all", stat_rd_o, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule